// File: doc/BRIEF.md
# Sequential Shift-and-Add Multiplier

This block multiplies two unsigned WIDTH-bit operands over several clock cycles. It has a small datapath and a hardwired three-state controller. The operands come in one after the other on a shared data bus. One strobe writes the bus into the multiplicand register and another writes it into the multiplier register. A start pulse then begins the run. The result is 2·WIDTH bits wide. Its upper half is an accumulator register and its lower half is the multiplier register. Multiplier bits shift out of the bottom of that register while finished product bits shift in at the top.

The controller handles one multiplier bit in two states. The add state (`ST_ADD`, code 01) adds the multiplicand into the accumulator when the multiplier's lowest bit is 1, and catches the adder's carry in a one-bit carry register. The shift state (`ST_SHIFT`, code 10) shifts carry, accumulator and multiplier right as one word, puts 0 into the carry and decrements a bit counter. The counter is tested for zero before the decrement. When it reads zero the controller returns to the idle state (`ST_IDLE`, code 00); otherwise it goes back to `ST_ADD`. The named transitions are:
- IDLE→ADD on start.
- IDLE→IDLE while start is low.
- ADD→SHIFT always.
- SHIFT→ADD when the count is not zero.
- SHIFT→IDLE when it is zero.
- The unused code 11 goes to IDLE.

In idle the product is held until the operands are reloaded.

Top module: `smul_top`

## Requirements
- R1: After a synchronous reset, `busy` is 0 and `product` is all zeros.
- R2: In idle, `ld_mcand`=1 stores `din` as the multiplicand and `ld_mplier`=1 stores `din` as the multiplier. The stored multiplier appears on `product[WIDTH-1:0]` after the next clock edge.
- R3: While `busy`=1, `ld_mcand` and `ld_mplier` have no effect, and the finished product uses the operands held when the run started.
- R4: `go`=1 in idle starts a run. `busy` rises at the next edge, stays high for exactly 2·WIDTH cycles, then falls.
- R5: When `busy` falls, `product` equals the unsigned product of the operands. The upper WIDTH bits are the high half and the lower WIDTH bits are the low half.
- R6: In idle with `go`=0 and no multiplier load, `product` holds its value.
- R7: A multiplier load in the same cycle as `go` is accepted, and the run multiplies by the newly loaded value.
- R8: A carry out of the add step is kept, so all-ones times all-ones gives the full 2·WIDTH-bit result.
- R9: `go` pulses while `busy`=1 are ignored: the run length and the result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | WIDTH | Shared operand bus |
| ld_mcand | input | 1 | Load multiplicand from `din` (idle only) |
| ld_mplier | input | 1 | Load multiplier from `din` (idle only) |
| go | input | 1 | Start strobe |
| product | output | 2·WIDTH | High half (accumulator) followed by low half (multiplier register) |
| busy | output | 1 | High whenever the controller is not idle |

## Verification
Two cases are provoked where a function falls on the same edge as another. In the first, a multiplier load is driven in the same cycle as `go`, so that the operand register is both written and starts being consumed at that edge. The scoreboard expects the product of the newly loaded value, so a design that used the old value is caught. In the second, `go` and both load strobes are pulsed in the middle of a run while the controller is shifting. The run must still end exactly 2·WIDTH cycles after its start with the original operands' product.

// File: rtl/smul_pkg.sv
package smul_pkg;
    // Controller state codes: bit 1 marks the shift phase, bit 0 the add phase.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_ADD   = 2'b01,
        ST_SHIFT = 2'b10
    } ctl_state_e;
endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl
    import smul_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic q_lsb,
    input  logic cnt_zero,
    output logic in_idle,
    output logic do_init,
    output logic do_add,
    output logic do_clr_c,
    output logic do_shift
);
    ctl_state_e state;
    ctl_state_e state_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Sequencing
    always_comb begin
        state_nxt = ST_IDLE;
        unique case (state)
            ST_IDLE:  state_nxt = go ? ST_ADD : ST_IDLE;
            ST_ADD:   state_nxt = ST_SHIFT;
            ST_SHIFT: state_nxt = cnt_zero ? ST_IDLE : ST_ADD;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    // Control outputs from the decoded state
    always_comb begin
        in_idle  = 1'b0;
        do_init  = 1'b0;
        do_add   = 1'b0;
        do_clr_c = 1'b0;
        do_shift = 1'b0;
        unique case (state)
            ST_IDLE: begin
                in_idle  = 1'b1;
                do_init  = go;
                do_clr_c = go;
            end
            ST_ADD: begin
                do_add = q_lsb;
            end
            ST_SHIFT: begin
                do_clr_c = 1'b1;
                do_shift = 1'b1;
            end
            default: begin
                in_idle = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/smul_dpath.sv
module smul_dpath #(
    parameter int WIDTH = 8,
    parameter int CW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    input  logic             ld_b,
    input  logic             ld_q,
    input  logic             do_init,
    input  logic             do_add,
    input  logic             do_clr_c,
    input  logic             do_shift,
    output logic [WIDTH-1:0] b_q,
    output logic [WIDTH-1:0] a_q,
    output logic [WIDTH-1:0] q_q,
    output logic             c_q,
    output logic [CW-1:0]    p_q,
    output logic             cnt_zero
);
    localparam logic [CW-1:0] CNT_START = CW'(WIDTH - 1);

    logic [WIDTH:0] sum;
    assign sum = {1'b0, a_q} + {1'b0, b_q};

    // Multiplicand
    always_ff @(posedge clk) begin
        if (rst) begin
            b_q <= '0;
        end else if (ld_b) begin
            b_q <= din;
        end
    end

    // Accumulator and carry
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            c_q <= 1'b0;
        end else begin
            if (do_init) begin
                a_q <= '0;
            end else if (do_add) begin
                a_q <= sum[WIDTH-1:0];
            end else if (do_shift) begin
                a_q <= {c_q, a_q[WIDTH-1:1]};
            end
            if (do_clr_c) begin
                c_q <= 1'b0;
            end else if (do_add) begin
                c_q <= sum[WIDTH];
            end
        end
    end

    // Multiplier / low product half
    always_ff @(posedge clk) begin
        if (rst) begin
            q_q <= '0;
        end else if (ld_q) begin
            q_q <= din;
        end else if (do_shift) begin
            if (WIDTH > 1) begin
                q_q <= {a_q[0], q_q[WIDTH-1:1]};
            end else begin
                q_q <= a_q[0:0];
            end
        end
    end

    // Bit counter with zero detect on the pre-decrement value
    always_ff @(posedge clk) begin
        if (rst) begin
            p_q <= '0;
        end else if (do_init) begin
            p_q <= CNT_START;
        end else if (do_shift) begin
            p_q <= p_q - 1'b1;
        end
    end

    assign cnt_zero = (p_q == '0);
endmodule

// File: rtl/smul_top.sv
module smul_top #(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WIDTH-1:0]   din,
    input  logic               ld_mcand,
    input  logic               ld_mplier,
    input  logic               go,
    output logic [2*WIDTH-1:0] product,
    output logic               busy
);
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

    logic             in_idle;
    logic             do_init;
    logic             do_add;
    logic             do_clr_c;
    logic             do_shift;
    logic [WIDTH-1:0] b_q;
    logic [WIDTH-1:0] a_q;
    logic [WIDTH-1:0] q_q;
    logic             c_q;
    logic [CW-1:0]    p_q;
    logic             cnt_zero;

    smul_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .go       (go),
        .q_lsb    (q_q[0]),
        .cnt_zero (cnt_zero),
        .in_idle  (in_idle),
        .do_init  (do_init),
        .do_add   (do_add),
        .do_clr_c (do_clr_c),
        .do_shift (do_shift)
    );

    smul_dpath #(
        .WIDTH (WIDTH),
        .CW    (CW)
    ) u_dp (
        .clk      (clk),
        .rst      (rst),
        .din      (din),
        .ld_b     (ld_mcand & in_idle),
        .ld_q     (ld_mplier & in_idle),
        .do_init  (do_init),
        .do_add   (do_add),
        .do_clr_c (do_clr_c),
        .do_shift (do_shift),
        .b_q      (b_q),
        .a_q      (a_q),
        .q_q      (q_q),
        .c_q      (c_q),
        .p_q      (p_q),
        .cnt_zero (cnt_zero)
    );

    assign product = {a_q, q_q};
    assign busy    = ~in_idle;
endmodule

// File: rtl/smul_chk.sv
module smul_chk #(
    parameter int WIDTH = 8,
    parameter int CW    = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               go,
    input logic               ld_mplier,
    input logic               busy,
    input logic [2*WIDTH-1:0] product,
    input logic [WIDTH-1:0]   b_q,
    input logic               c_q,
    input logic [CW-1:0]      p_q,
    input logic               cnt_zero,
    input logic               do_shift
);
    // R4: start from idle makes the block busy on the next edge
    p_start_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (!busy && go) |=> busy);

    // R4: counter is loaded with WIDTH-1 when a run begins
    p_count_load_r4: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (p_q == CW'(WIDTH - 1)));

    // R4: a shift seen with a zero count ends the run
    p_finish_r4: assert property (@(posedge clk) disable iff (rst)
        (do_shift && cnt_zero) |=> !busy);

    // R3: multiplicand cannot change during a run
    p_mcand_frozen_r3: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(b_q));

    // R6: idle without start or multiplier load keeps the product
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !go && !ld_mplier) |=> $stable(product));

    // R8: carry register is emptied by every shift
    p_carry_cleared_r8: assert property (@(posedge clk) disable iff (rst)
        do_shift |=> !c_q);
endmodule

bind smul_top smul_chk #(
    .WIDTH (WIDTH),
    .CW    (CW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .ld_mplier (ld_mplier),
    .busy      (busy),
    .product   (product),
    .b_q       (b_q),
    .c_q       (c_q),
    .p_q       (p_q),
    .cnt_zero  (cnt_zero),
    .do_shift  (do_shift)
);

// File: tb/smul_top_tb.sv
module smul_top_tb;
    localparam int W  = 8;
    localparam int PW = 2 * W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [W-1:0]  din = '0;
    logic          ld_mcand = 1'b0;
    logic          ld_mplier = 1'b0;
    logic          go = 1'b0;
    logic [PW-1:0] product;
    logic          busy;

    int n_checks = 0;
    int n_fail   = 0;
    int watchdog = 0;
    bit done     = 1'b0;

    logic [PW-1:0] exp_q[$];
    string         tag_q[$];

    always #10 clk = ~clk;   // 50 MHz

    smul_top #(.WIDTH(W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .din       (din),
        .ld_mcand  (ld_mcand),
        .ld_mplier (ld_mplier),
        .go        (go),
        .product   (product),
        .busy      (busy)
    );

    task automatic check(input bit ok, input string req, input logic [PW-1:0] act,
                         input logic [PW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Monitor: counts busy cycles and compares each finished run
    int busy_cnt = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) begin
                busy_cnt++;
            end else if (busy_cnt != 0) begin
                logic [PW-1:0] e;
                string t;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected run", product, '0);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(product == e, {t, " product"}, product, e);
                    check(busy_cnt == 2 * W, {"R4 run length ", t},
                          PW'(busy_cnt), PW'(2 * W));
                end
                busy_cnt = 0;
            end
        end
    end

    task automatic load_b(input logic [W-1:0] v);
        @(negedge clk);
        din = v; ld_mcand = 1'b1;
        @(negedge clk);
        ld_mcand = 1'b0;
    endtask

    task automatic load_q(input logic [W-1:0] v);
        @(negedge clk);
        din = v; ld_mplier = 1'b1;
        @(negedge clk);
        ld_mplier = 1'b0;
        check(product[W-1:0] == v, "R2 multiplier load", PW'(product[W-1:0]), PW'(v));
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_pair(input logic [W-1:0] a, input logic [W-1:0] b, input string t);
        load_b(a);
        load_q(b);
        @(negedge clk);
        go = 1'b1;
        exp_q.push_back(PW'(a) * PW'(b));
        tag_q.push_back(t);
        @(negedge clk);
        go = 1'b0;
        wait_done();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R1 busy after reset", PW'(busy), '0);
        check(product == '0, "R1 product after reset", product, '0);
        rst = 1'b0;

        run_pair(8'd5,   8'd3,   "R5 small");
        run_pair(8'd0,   8'd200, "R5 zero");
        run_pair(8'd1,   8'd173, "R5 one");
        run_pair(8'd255, 8'd255, "R8 all-ones");
        run_pair(8'd128, 8'd255, "R8 carry");
        for (int i = 0; i < 20; i++) begin
            run_pair(W'($urandom), W'($urandom), "R5 random");
        end

        // R6: hold in idle, product must not move
        begin
            logic [PW-1:0] held;
            held = product;
            repeat (6) @(negedge clk);
            check(product == held, "R6 idle hold", product, held);
        end

        // R3 and R9: loads and start pulses during a run are ignored
        load_b(8'd37);
        load_q(8'd91);
        @(negedge clk);
        go = 1'b1;
        exp_q.push_back(PW'(37) * PW'(91));
        tag_q.push_back("R3 R9 mid-run stimulus");
        @(negedge clk);
        go = 1'b0;
        repeat (3) @(negedge clk);
        din = 8'hFF; ld_mcand = 1'b1; ld_mplier = 1'b1; go = 1'b1;
        @(negedge clk);
        ld_mcand = 1'b0;
        @(negedge clk);
        ld_mplier = 1'b0; go = 1'b0;
        @(negedge clk);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        wait_done();

        // R7: multiplier load coinciding with start
        load_b(8'd19);
        load_q(8'd2);
        @(negedge clk);
        din = 8'd201; ld_mplier = 1'b1; go = 1'b1;
        exp_q.push_back(PW'(19) * PW'(201));
        tag_q.push_back("R7 load with start");
        @(negedge clk);
        ld_mplier = 1'b0; go = 1'b0;
        wait_done();

        check(exp_q.size() == 0, "R4 all runs completed", PW'(exp_q.size()), '0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        watchdog++;
        if (watchdog > 150000 && !done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000", watchdog);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule